// File: doc/BRIEF.md
# Router Input Channel Sleep Controller

This controller sits beside one input channel of a mesh network router and decides when the channel's flit buffer may lose power. The channel powers down only when its buffer is empty, no wakeup request is pending and no flit is arriving. It powers up again when a flit arrives or when the upstream router sends a look-ahead wakeup request, which can come several cycles before the header flit. The controller drives a power-switch enable and an isolation signal. It also drives a ready indication that holds the router pipeline back until the channel has finished waking.

The controller also keeps three totals: powered cycles, cycles spent in sleeps long enough to pay back the switching energy, and cycles spent in sleeps that were too short. A sleep interval is classified once, on the cycle it ends, by comparing its length with the breakeven parameter. A synchronous clear resets the totals.

Top module: `chan_sleep_ctrl`

## Requirements
- R1: After reset the channel is powered and ready (`pwr_en_o`=1, `iso_o`=0, `ready_o`=1), and all three totals are zero.
- R2: A powered, ready channel becomes unpowered from the next cycle (`pwr_en_o`=0, `iso_o`=1, `ready_o`=0) when a clock edge samples `buf_empty_i`=1, `wake_req_i`=0 and `flit_in_i`=0 together. In any other case it stays powered.
- R3: While asleep, `wake_req_i`=1 or `flit_in_i`=1 raises `pwr_en_o` in that same cycle.
- R4: If a wakeup starts in cycle t, `ready_o` rises in cycle t+WAKE_DELAY and `iso_o` is low exactly when `ready_o` is high. With WAKE_DELAY=0, `ready_o` is high in cycle t itself.
- R5: A wakeup request or flit that arrives while the channel is still waking does not restart or stretch the wakeup count.
- R6: The active total grows by one for every cycle in which `pwr_en_o` is high.
- R7: A sleep interval is L consecutive cycles with `pwr_en_o` low. When it ends, L is added to the compensated total if L > BREAKEVEN, and to the uncompensated total otherwise. The new total is visible from the cycle after the wake cycle.
- R8: Every total saturates at 2^CNT_W-1 and does not wrap.
- R9: `clr_i`=1 zeroes all three totals at the next edge and takes priority over any increment in that cycle.
- R10: BREAKEVEN defaults to 6 and may be set to other lengths such as 14; the classification threshold follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the three totals |
| buf_empty_i | input | 1 | Channel flit buffer holds nothing |
| wake_req_i | input | 1 | Look-ahead wakeup request from upstream router |
| flit_in_i | input | 1 | Flit arriving at the channel this cycle |
| pwr_en_o | output | 1 | Power-switch enable |
| iso_o | output | 1 | Output isolation while not ready |
| ready_o | output | 1 | Channel may accept flits; low stalls the pipeline |
| active_cnt_o | output | CNT_W | Powered-cycle total |
| comp_cnt_o | output | CNT_W | Compensated sleep-cycle total |
| uncomp_cnt_o | output | CNT_W | Uncompensated sleep-cycle total |

## Verification
The bench builds two instances side by side from the same stimulus. The first has WAKE_DELAY=3, BREAKEVEN=6 and CNT_W=8. Its small counter width lets a run of a few hundred cycles reach saturation, and its delay leaves room for a second request to land mid-wake. The second has WAKE_DELAY=0, BREAKEVEN=14 and CNT_W=32, which covers same-cycle readiness and the longer threshold. Sleep lengths from 1 to 20 cycles, plus one of 300 cycles, are swept, so each instance sees intervals on both sides of its breakeven and exactly at it. Wakeups alternate between request-driven and flit-driven.

// File: rtl/chan_sleep_ctrl.sv
module chan_sleep_ctrl #(
  parameter int WAKE_DELAY = 3,
  parameter int BREAKEVEN  = 6,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             buf_empty_i,
  input  logic             wake_req_i,
  input  logic             flit_in_i,
  output logic             pwr_en_o,
  output logic             iso_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] active_cnt_o,
  output logic [CNT_W-1:0] comp_cnt_o,
  output logic [CNT_W-1:0] uncomp_cnt_o
);

  localparam int DW = (WAKE_DELAY > 1) ? $clog2(WAKE_DELAY + 1) : 1;

  typedef enum logic [1:0] {ST_ACT, ST_SLP, ST_WAK} st_t;

  st_t             st_q;
  logic [DW-1:0]   wcnt_q;
  logic [CNT_W-1:0] slen_q, act_q, comp_q, unc_q;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  wire idle      = buf_empty_i & ~wake_req_i & ~flit_in_i;
  wire wake_any  = wake_req_i | flit_in_i;
  wire end_sleep = (st_q == ST_SLP) & wake_any;

  assign pwr_en_o = (st_q != ST_SLP) | wake_any;
  assign ready_o  = (st_q == ST_ACT) | ((WAKE_DELAY == 0) & end_sleep);
  assign iso_o    = ~ready_o;

  assign active_cnt_o = act_q;
  assign comp_cnt_o   = comp_q;
  assign uncomp_cnt_o = unc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ACT;
      wcnt_q <= '0;
      slen_q <= '0;
    end else begin
      unique case (st_q)
        ST_ACT: begin
          slen_q <= '0;
          if (idle) st_q <= ST_SLP;
        end
        ST_SLP: begin
          if (wake_any) begin
            if (WAKE_DELAY <= 1) st_q <= ST_ACT;
            else begin
              st_q   <= ST_WAK;
              wcnt_q <= DW'(WAKE_DELAY - 1);
            end
          end else begin
            slen_q <= sat_add(slen_q, CNT_W'(1));
          end
        end
        ST_WAK: begin
          if (wcnt_q <= DW'(1)) st_q <= ST_ACT;
          else wcnt_q <= wcnt_q - DW'(1);
        end
        default: st_q <= ST_ACT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      comp_q <= '0;
      unc_q  <= '0;
    end else if (clr_i) begin
      act_q  <= '0;
      comp_q <= '0;
      unc_q  <= '0;
    end else begin
      if (pwr_en_o) act_q <= sat_add(act_q, CNT_W'(1));
      if (end_sleep) begin
        if (slen_q > CNT_W'(BREAKEVEN)) comp_q <= sat_add(comp_q, slen_q);
        else                            unc_q  <= sat_add(unc_q, slen_q);
      end
    end
  end

  p_stay_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && !idle) |=> pwr_en_o);

  p_sleep_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLP && !wake_any) |-> (!pwr_en_o && iso_o && !ready_o));

  p_wake_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLP && wake_any) |-> pwr_en_o);

  p_ready_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> pwr_en_o);

  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAK && wcnt_q > DW'(1)) |=>
      (st_q == ST_WAK && wcnt_q == $past(wcnt_q) - DW'(1)));

  p_act_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> act_q >= $past(act_q));

  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (act_q == '0 && comp_q == '0 && unc_q == '0));

endmodule

// File: tb/chan_sleep_ctrl_tb_top.sv
module chan_sleep_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, bempty = 1'b0, wreq = 1'b0, fin = 1'b0;
  logic a_pwr, a_iso, a_rdy, b_pwr, b_iso, b_rdy;
  logic [7:0]  a_act, a_cmp, a_unc;
  logic [31:0] b_act, b_cmp, b_unc;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chan_sleep_ctrl #(.WAKE_DELAY(3), .BREAKEVEN(6), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .buf_empty_i(bempty),
    .wake_req_i(wreq), .flit_in_i(fin), .pwr_en_o(a_pwr), .iso_o(a_iso),
    .ready_o(a_rdy), .active_cnt_o(a_act), .comp_cnt_o(a_cmp),
    .uncomp_cnt_o(a_unc));

  chan_sleep_ctrl #(.WAKE_DELAY(0), .BREAKEVEN(14), .CNT_W(32)) dut_b (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .buf_empty_i(bempty),
    .wake_req_i(wreq), .flit_in_i(fin), .pwr_en_o(b_pwr), .iso_o(b_iso),
    .ready_o(b_rdy), .active_cnt_o(b_act), .comp_cnt_o(b_cmp),
    .uncomp_cnt_o(b_unc));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nx;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) nx();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(a_pwr && !a_iso && a_rdy, "R1 a outputs", {a_pwr, a_iso, a_rdy}, 3'b101);
    chk(b_pwr && !b_iso && b_rdy, "R1 b outputs", {b_pwr, b_iso, b_rdy}, 3'b101);
    chk(a_act == 0 && a_cmp == 0 && a_unc == 0, "R1 a totals", a_act, 0);
    chk(b_act == 0 && b_cmp == 0 && b_unc == 0, "R1 b totals", b_act, 0);

    // R2: empty buffer but flit arriving keeps the channel awake
    nx(); bempty = 1'b1; fin = 1'b1;
    nx(); #1;
    chk(a_pwr && a_rdy, "R2 flit in flight blocks sleep a", a_pwr, 1);
    chk(b_pwr && b_rdy, "R2 flit in flight blocks sleep b", b_pwr, 1);
    bempty = 1'b1; fin = 1'b0; wreq = 1'b1;
    nx(); #1;
    chk(a_pwr && a_rdy, "R2 request blocks sleep", a_pwr, 1);
    bempty = 1'b0; wreq = 1'b0;
    nx();

    // Sleep-length sweep (R2, R3, R4, R5, R6, R7, R10)
    for (int k = 1; k <= 21; k++) begin
      automatic int L = (k == 21) ? 300 : k;
      automatic bit use_flit = (k % 2 == 1);
      automatic longint exp_cmp_a = (L > 6)  ? ((L > 255) ? 255 : L) : 0;
      automatic longint exp_unc_a = (L > 6)  ? 0 : L;
      automatic longint exp_cmp_b = (L > 14) ? L : 0;
      automatic longint exp_unc_b = (L > 14) ? 0 : L;
      clr = 1'b1;
      nx(); clr = 1'b0; bempty = 1'b1;
      nx(); #1;
      chk(!a_pwr && a_iso && !a_rdy, "R2 a asleep", {a_pwr, a_iso, a_rdy}, 3'b010);
      chk(!b_pwr && b_iso && !b_rdy, "R2 b asleep", {b_pwr, b_iso, b_rdy}, 3'b010);
      repeat (L) nx();
      if (use_flit) fin = 1'b1; else wreq = 1'b1;
      bempty = 1'b0;
      #1;
      chk(a_pwr, "R3 a wake same cycle", a_pwr, 1);
      chk(b_pwr, "R3 b wake same cycle", b_pwr, 1);
      chk(!a_rdy && a_iso, "R4 a not ready at t", a_rdy, 0);
      chk(b_rdy && !b_iso, "R4 b ready at t (delay 0)", b_rdy, 1);
      nx(); fin = 1'b0; wreq = 1'b1;
      #1;
      chk(a_cmp == exp_cmp_a, "R7 a compensated", a_cmp, exp_cmp_a);
      chk(a_unc == exp_unc_a, "R7 a uncompensated", a_unc, exp_unc_a);
      chk(b_cmp == exp_cmp_b, "R10 b compensated", b_cmp, exp_cmp_b);
      chk(b_unc == exp_unc_b, "R10 b uncompensated", b_unc, exp_unc_b);
      chk(!a_rdy, "R4 a not ready at t+1", a_rdy, 0);
      nx(); wreq = 1'b0;
      #1;
      chk(!a_rdy, "R5 a not ready at t+2", a_rdy, 0);
      nx(); #1;
      chk(a_rdy && !a_iso, "R5 a ready at t+3", a_rdy, 1);
      chk(a_act == 4, "R6 a active total", a_act, 4);
      chk(b_act == 4, "R6 b active total", b_act, 4);
      nx();
    end

    // R8 saturation and R9 clear
    clr = 1'b1;
    nx(); clr = 1'b0;
    #1;
    chk(a_act == 0 && b_act == 0, "R9 clear zeroes totals", b_act, 0);
    chk(a_cmp == 0 && b_cmp == 0, "R9 clear zeroes compensated", b_cmp, 0);
    repeat (300) nx();
    #1;
    chk(a_act == 255, "R8 a active saturates", a_act, 255);
    chk(b_act == 300, "R6 b active counts", b_act, 300);
    clr = 1'b1;
    nx(); #1;
    chk(a_act == 0, "R9 clear over increment", a_act, 0);
    clr = 1'b0;
    nx();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule